// File: doc/BRIEF.md
# Multi-Mode Snooping Coherence Controller

This block keeps the coherence state of a small set of tracked lines for several private caches that share one memory over a broadcast snoop bus. Each cache raises a request (read, write or evict) for one line and holds it until the block reports completion. The block grants one requester at a time in round-robin order and broadcasts the snoop to every cache. It then works out which caches answer with data and whether memory must supply the line or take a writeback. Finally it rewrites the state of that line in every cache.

A mode input selects one of three rule sets at run time. The rule sets differ in what happens when a line is already shared. In the three-state-plus-exclusive mode every Shared holder replies. In the owned-state mode only the Owned holder replies. In the forward-state mode only the Forward holder replies. The block reports the set of responders and their count for every request, so the extra traffic of the first mode can be seen directly at the ports. There are no data arrays and no replacement policy; the block only handles state, who responds, and memory traffic.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line in every cache is Invalid and `snoop_valid`, `mem_wb_valid`, `done_valid` and `mem_rd_valid` are low. State codes on `line_state` are I=0, S=1, E=2, M=3, O=4, F=5, in field `((cache*NUM_LINES)+line)*3`.
- R2: A read by a cache in I broadcasts a snoop one cycle after the grant. If no other cache holds the line, memory supplies it (`mem_rd_valid` with `done_valid`), no cache responds, and the requester ends in E.
- R3: In mode 0 (MESI), a read that finds another cache in E moves that cache to S. That cache is the only responder, there is no writeback, and the requester ends in S.
- R4: In mode 0 or mode 2 (MESIF), a read that finds another cache in M gives a writeback from that cache in its own cycle. The states then change, the holder to S and the requester to S. The forward from the holder is reported one cycle after the writeback.
- R5: In mode 0, every cache holding the line in S responds, so the response count equals the number of S holders.
- R6: In mode 1 (MOESI), a read that finds another cache in E or M moves that cache to O. The holder forwards the data and no writeback occurs.
- R7: In mode 1, when an O holder exists, only the O holder responds and the S holders stay silent.
- R8: In mode 2, a read that finds another cache in E moves that cache to F. Later reads are answered by the F holder alone.
- R9: A write (op 1) leaves the writer in M and every other copy in I. Any other copy in M or O is written back first. No cache responds and no memory read is made.
- R10: An evict (op 2) moves the requester to I. A line in M or O is written back first; a line in E, S or F is dropped without a writeback.
- R11: A read (op 0) by a cache whose copy is already valid changes no state, has no responder, no memory read and no writeback.
- R12: Simultaneous requests are granted round-robin, starting after the most recently granted cache.
- R13: In modes 1 and 2, no request ever has more than one responder.
- R14: In modes 1 and 2, a read that finds only S copies gets its data from memory with no responder, and the requester ends in S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 MESI, 1 MOESI, 2 MESIF rules |
| req_valid | input | NUM_CACHES | Per-cache request, held until done |
| req_op | input | 2*NUM_CACHES | Per-cache op: 0 read, 1 write, 2 evict |
| req_line | input | NUM_CACHES*LINE_W | Per-cache tracked line index |
| snoop_valid | output | 1 | Snoop broadcast cycle |
| snoop_src | output | CACHE_W | Cache that caused the snoop |
| snoop_line | output | LINE_W | Line being snooped |
| snoop_op | output | 2 | Op being snooped |
| mem_wb_valid | output | 1 | Writeback to memory this cycle |
| mem_wb_src | output | CACHE_W | Cache supplying the writeback |
| mem_wb_line | output | LINE_W | Line written back |
| mem_rd_valid | output | 1 | Memory supplies the requester's line |
| mem_rd_line | output | LINE_W | Line read from memory |
| done_valid | output | 1 | Request completes this cycle |
| done_id | output | CACHE_W | Cache whose request completes |
| resp_mask | output | NUM_CACHES | Caches forwarding data for this request |
| resp_count | output | CNT_W | Number of data responders |
| line_state | output | NUM_CACHES*NUM_LINES*3 | State of every tracked line |

## Verification
A request presented before a clock edge in idle shows `snoop_valid` one cycle after that edge. Without a writeback, `done_valid` with the responders and the memory read follows one cycle later. With a writeback, `mem_wb_valid` takes that cycle and `done_valid` comes one cycle after it. The new states appear on `line_state` in the same cycle as `done_valid`. Each scenario task counts falling edges from the moment it raises its request and checks the cycle of each event against these latencies, and checks states in the done cycle.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        MODE_MESI  = 2'd0,
        MODE_MOESI = 2'd1,
        MODE_MESIF = 2'd2
    } coh_mode_e;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_M = 3'd3,
        ST_O = 3'd4,
        ST_F = 3'd5
    } line_st_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NONE  = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SNOOP = 2'd1,
        PH_WB    = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    localparam int ST_W = 3;

    function automatic logic is_dirty(line_st_e s);
        return (s == ST_M) || (s == ST_O);
    endfunction

    function automatic logic is_owner(line_st_e s);
        return (s == ST_M) || (s == ST_E) || (s == ST_O) || (s == ST_F);
    endfunction

    // Next state of a remote holder after another cache reads the line.
    function automatic line_st_e remote_after_read(line_st_e s, coh_mode_e m);
        line_st_e r;
        r = s;
        case (s)
            ST_M: r = (m == MODE_MOESI) ? ST_O : ST_S;
            ST_E: begin
                case (m)
                    MODE_MOESI: r = ST_O;
                    MODE_MESIF: r = ST_F;
                    default:    r = ST_S;
                endcase
            end
            default: r = s;
        endcase
        return r;
    endfunction

    // Does a holder in state s answer a read snoop under mode m.
    function automatic logic answers_read(line_st_e s, coh_mode_e m);
        return is_owner(s) || ((s == ST_S) && (m == MODE_MESI));
    endfunction

endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb
    import coh_pkg::*;
#(
    parameter int N = 4,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          accept,
    output logic          grant_any,
    output logic [CW-1:0] grant_id
);

    logic [CW-1:0] ptr_q;

    always_comb begin
        grant_any = 1'b0;
        grant_id  = '0;
        for (int off = N - 1; off >= 0; off--) begin
            int idx;
            idx = (int'(ptr_q) + off) % N;
            if (req[idx]) begin
                grant_any = 1'b1;
                grant_id  = CW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (accept && grant_any) begin
            ptr_q <= CW'((int'(grant_id) + 1) % N);
        end
    end

    AST_GRANT_IS_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        grant_any |-> req[grant_id]) else $error("grant to idle cache"); // R12

endmodule

// File: rtl/coh_state_store.sv
module coh_state_store
    import coh_pkg::*;
#(
    parameter int N = 4,
    parameter int L = 4,
    localparam int LW = (L > 1) ? $clog2(L) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LW-1:0]     wr_line,
    input  logic [N*ST_W-1:0] wr_vec,
    input  logic [LW-1:0]     rd_line,
    output logic [N*ST_W-1:0] rd_vec,
    output logic [N*L*ST_W-1:0] all_st
);

    line_st_e st_q [N][L];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < N; c++) begin
                for (int l = 0; l < L; l++) begin
                    st_q[c][l] <= ST_I;
                end
            end
        end else if (wr_en) begin
            for (int c = 0; c < N; c++) begin
                st_q[c][wr_line] <= line_st_e'(wr_vec[c*ST_W +: ST_W]);
            end
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_cache
        assign rd_vec[c*ST_W +: ST_W] = st_q[c][rd_line];
        for (genvar l = 0; l < L; l++) begin : g_line
            assign all_st[(c*L + l)*ST_W +: ST_W] = st_q[c][l];
        end
    end

    for (genvar l = 0; l < L; l++) begin : g_chk
        logic [N-1:0] own_mask;
        for (genvar c = 0; c < N; c++) begin : g_own
            assign own_mask[c] = is_owner(st_q[c][l]);
        end
        AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
            $countones(own_mask) <= 1) else $error("two owners of a line"); // R9
    end

endmodule

// File: rtl/coh_snoop_resolve.sv
module coh_snoop_resolve
    import coh_pkg::*;
#(
    parameter int N = 4,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  coh_mode_e         mode,
    input  req_op_e           op,
    input  logic [CW-1:0]     req_id,
    input  logic [N*ST_W-1:0] cur_vec,
    output logic [N*ST_W-1:0] nxt_vec,
    output logic [N-1:0]      resp_mask,
    output logic              mem_rd,
    output logic              need_wb,
    output logic [CW-1:0]     wb_src
);

    line_st_e cur [N];
    line_st_e nxt [N];

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign cur[g] = line_st_e'(cur_vec[g*ST_W +: ST_W]);
        assign nxt_vec[g*ST_W +: ST_W] = nxt[g];
    end

    always_comb begin
        logic any_other;
        any_other = 1'b0;
        resp_mask = '0;
        mem_rd    = 1'b0;
        need_wb   = 1'b0;
        wb_src    = '0;
        for (int i = 0; i < N; i++) begin
            nxt[i] = cur[i];
        end
        case (op)
            OP_READ: begin
                if (cur[req_id] == ST_I) begin
                    for (int i = 0; i < N; i++) begin
                        if (i != int'(req_id) && cur[i] != ST_I) begin
                            any_other    = 1'b1;
                            resp_mask[i] = answers_read(cur[i], mode);
                            nxt[i]       = remote_after_read(cur[i], mode);
                            if (cur[i] == ST_M && mode != MODE_MOESI) begin
                                need_wb = 1'b1;
                                wb_src  = CW'(i);
                            end
                        end
                    end
                    nxt[req_id] = any_other ? ST_S : ST_E;
                    mem_rd      = (resp_mask == '0);
                end
            end
            OP_WRITE: begin
                for (int i = 0; i < N; i++) begin
                    if (i != int'(req_id)) begin
                        if (is_dirty(cur[i])) begin
                            need_wb = 1'b1;
                            wb_src  = CW'(i);
                        end
                        nxt[i] = ST_I;
                    end
                end
                nxt[req_id] = ST_M;
            end
            OP_EVICT: begin
                if (is_dirty(cur[req_id])) begin
                    need_wb = 1'b1;
                    wb_src  = req_id;
                end
                nxt[req_id] = ST_I;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
    import coh_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int NUM_LINES  = 4,
    localparam int CACHE_W = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1,
    localparam int LINE_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int CNT_W   = $clog2(NUM_CACHES + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [1:0]                        mode,
    input  logic [NUM_CACHES-1:0]             req_valid,
    input  logic [2*NUM_CACHES-1:0]           req_op,
    input  logic [NUM_CACHES*LINE_W-1:0]      req_line,
    output logic                              snoop_valid,
    output logic [CACHE_W-1:0]                snoop_src,
    output logic [LINE_W-1:0]                 snoop_line,
    output logic [1:0]                        snoop_op,
    output logic                              mem_wb_valid,
    output logic [CACHE_W-1:0]                mem_wb_src,
    output logic [LINE_W-1:0]                 mem_wb_line,
    output logic                              mem_rd_valid,
    output logic [LINE_W-1:0]                 mem_rd_line,
    output logic                              done_valid,
    output logic [CACHE_W-1:0]                done_id,
    output logic [NUM_CACHES-1:0]             resp_mask,
    output logic [CNT_W-1:0]                  resp_count,
    output logic [NUM_CACHES*NUM_LINES*3-1:0] line_state
);

    localparam int VEC_W = NUM_CACHES * ST_W;

    phase_e              ph_q;
    logic [CACHE_W-1:0]  cur_id_q;
    req_op_e             cur_op_q;
    logic [LINE_W-1:0]   cur_line_q;
    logic [NUM_CACHES-1:0] resp_q;
    logic                memrd_q;
    logic [CACHE_W-1:0]  wbsrc_q;
    logic [VEC_W-1:0]    nxt_q;

    logic                grant_any;
    logic [CACHE_W-1:0]  grant_id;
    logic                accept;

    logic [VEC_W-1:0]    cur_vec;
    logic [VEC_W-1:0]    res_nxt;
    logic [NUM_CACHES-1:0] res_resp;
    logic                res_memrd;
    logic                res_wb;
    logic [CACHE_W-1:0]  res_wbsrc;

    logic                st_wr_en;
    logic [VEC_W-1:0]    st_wr_vec;

    assign accept = (ph_q == PH_IDLE);

    coh_rr_arb #(.N(NUM_CACHES)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req_valid),
        .accept    (accept),
        .grant_any (grant_any),
        .grant_id  (grant_id)
    );

    coh_state_store #(.N(NUM_CACHES), .L(NUM_LINES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (st_wr_en),
        .wr_line (cur_line_q),
        .wr_vec  (st_wr_vec),
        .rd_line (cur_line_q),
        .rd_vec  (cur_vec),
        .all_st  (line_state)
    );

    coh_snoop_resolve #(.N(NUM_CACHES)) u_resolve (
        .mode      (coh_mode_e'(mode)),
        .op        (cur_op_q),
        .req_id    (cur_id_q),
        .cur_vec   (cur_vec),
        .nxt_vec   (res_nxt),
        .resp_mask (res_resp),
        .mem_rd    (res_memrd),
        .need_wb   (res_wb),
        .wb_src    (res_wbsrc)
    );

    // States are committed after the writeback cycle, before the forward.
    assign st_wr_en  = ((ph_q == PH_SNOOP) && !res_wb) || (ph_q == PH_WB);
    assign st_wr_vec = (ph_q == PH_WB) ? nxt_q : res_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_IDLE;
            cur_id_q   <= '0;
            cur_op_q   <= OP_NONE;
            cur_line_q <= '0;
            resp_q     <= '0;
            memrd_q    <= 1'b0;
            wbsrc_q    <= '0;
            nxt_q      <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (grant_any) begin
                        cur_id_q   <= grant_id;
                        cur_op_q   <= req_op_e'(req_op[grant_id*2 +: 2]);
                        cur_line_q <= req_line[grant_id*LINE_W +: LINE_W];
                        ph_q       <= PH_SNOOP;
                    end
                end
                PH_SNOOP: begin
                    resp_q  <= res_resp;
                    memrd_q <= res_memrd;
                    wbsrc_q <= res_wbsrc;
                    nxt_q   <= res_nxt;
                    ph_q    <= res_wb ? PH_WB : PH_DONE;
                end
                PH_WB:   ph_q <= PH_DONE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        resp_count = '0;
        for (int i = 0; i < NUM_CACHES; i++) begin
            resp_count = resp_count + CNT_W'(resp_mask[i]);
        end
    end

    assign snoop_valid  = (ph_q == PH_SNOOP);
    assign snoop_src    = cur_id_q;
    assign snoop_line   = cur_line_q;
    assign snoop_op     = cur_op_q;
    assign mem_wb_valid = (ph_q == PH_WB);
    assign mem_wb_src   = wbsrc_q;
    assign mem_wb_line  = cur_line_q;
    assign done_valid   = (ph_q == PH_DONE);
    assign done_id      = cur_id_q;
    assign resp_mask    = done_valid ? resp_q : '0;
    assign mem_rd_valid = done_valid && memrd_q;
    assign mem_rd_line  = cur_line_q;

    AST_SNOOP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        snoop_valid |=> (mem_wb_valid || done_valid)) else $error("snoop stalled"); // R2

    AST_WB_BEFORE_FWD: assert property (@(posedge clk) disable iff (rst)
        mem_wb_valid |=> done_valid) else $error("writeback not followed by done"); // R4

    AST_ONE_RESPONDER: assert property (@(posedge clk) disable iff (rst)
        (done_valid && mode != 2'd0) |-> (resp_count <= 1)) else $error("redundant responders"); // R13

    AST_MEM_OR_CACHE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> (resp_count == 0)) else $error("memory and cache both supplied"); // R14

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid) else $error("done held"); // R12

endmodule

// File: tb/coh_snoop_ctrl_tb_top.sv
module coh_snoop_ctrl_tb_top;

    localparam int NC = 4;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic [3:0]  req_valid = '0;
    logic [7:0]  req_op = '0;
    logic [7:0]  req_line = '0;
    logic        snoop_valid;
    logic [1:0]  snoop_src;
    logic [1:0]  snoop_line;
    logic [1:0]  snoop_op;
    logic        mem_wb_valid;
    logic [1:0]  mem_wb_src;
    logic [1:0]  mem_wb_line;
    logic        mem_rd_valid;
    logic [1:0]  mem_rd_line;
    logic        done_valid;
    logic [1:0]  done_id;
    logic [3:0]  resp_mask;
    logic [2:0]  resp_count;
    logic [NC*NL*3-1:0] line_state;

    int n_tests = 0;
    int n_fail  = 0;

    int t_snoop, t_wb, t_wb_src, t_wb_cyc, t_done_cyc, t_done_id;
    int t_count, t_mask, t_memrd;

    always #10 clk = ~clk;

    coh_snoop_ctrl #(.NUM_CACHES(NC), .NUM_LINES(NL)) dut_i (
        .clk(clk), .rst(rst), .mode(mode),
        .req_valid(req_valid), .req_op(req_op), .req_line(req_line),
        .snoop_valid(snoop_valid), .snoop_src(snoop_src),
        .snoop_line(snoop_line), .snoop_op(snoop_op),
        .mem_wb_valid(mem_wb_valid), .mem_wb_src(mem_wb_src), .mem_wb_line(mem_wb_line),
        .mem_rd_valid(mem_rd_valid), .mem_rd_line(mem_rd_line),
        .done_valid(done_valid), .done_id(done_id),
        .resp_mask(resp_mask), .resp_count(resp_count),
        .line_state(line_state)
    );

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int st_of(int c, int l);
        return int'(line_state[(c*NL + l)*3 +: 3]);
    endfunction

    task automatic chk_st(string tag, int c, int l, int exp);
        check($sformatf("%s state c%0d l%0d", tag, c, l), st_of(c, l), exp);
    endtask

    task automatic apply_reset(int m);
        @(negedge clk);
        rst = 1'b1; mode = m[1:0]; req_valid = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Issue one request and follow it to completion, counting falling edges.
    task automatic issue(int c, int op, int ln);
        int cyc;
        cyc = 0; t_snoop = 0; t_wb = 0; t_wb_src = -1; t_wb_cyc = 0;
        t_done_cyc = 0; t_done_id = -1; t_count = -1; t_mask = -1; t_memrd = -1;
        @(negedge clk);
        req_op[c*2 +: 2] = op[1:0];
        req_line[c*2 +: 2] = ln[1:0];
        req_valid[c] = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            if (snoop_valid && t_snoop == 0) t_snoop = cyc;
            if (mem_wb_valid) begin
                t_wb = 1; t_wb_src = int'(mem_wb_src); t_wb_cyc = cyc;
                check("wb line", int'(mem_wb_line), ln);
            end
            if (done_valid) begin
                t_done_cyc = cyc; t_done_id = int'(done_id);
                t_count = int'(resp_count); t_mask = int'(resp_mask);
                t_memrd = int'(mem_rd_valid);
                break;
            end
            if (cyc > 20) begin
                check("request timeout", cyc, 3);
                break;
            end
        end
        req_valid[c] = 1'b0;
    endtask

    task automatic expect_txn(string tag, int c, int wb, int wbsrc, int cnt, int mask, int memrd);
        check({tag, " snoop cycle"}, t_snoop, 1);
        check({tag, " done id"}, t_done_id, c);
        check({tag, " done cycle"}, t_done_cyc, (wb != 0) ? 3 : 2);
        check({tag, " writeback"}, t_wb, wb);
        if (wb != 0) begin
            check({tag, " wb source"}, t_wb_src, wbsrc);
            check({tag, " wb cycle"}, t_wb_cyc, 2);
        end
        check({tag, " resp count"}, t_count, cnt);
        check({tag, " resp mask"}, t_mask, mask);
        check({tag, " mem read"}, t_memrd, memrd);
    endtask

    task automatic test_reset();
        apply_reset(0);
        @(negedge clk);
        for (int c = 0; c < NC; c++)
            for (int l = 0; l < NL; l++)
                chk_st("R1 reset", c, l, 0);
        check("R1 idle outputs", int'({snoop_valid, mem_wb_valid, done_valid, mem_rd_valid}), 0);
    endtask

    task automatic test_mesi();
        apply_reset(0);
        issue(0, 0, 0);
        expect_txn("R2 cold read", 0, 0, 0, 0, 0, 1);
        chk_st("R2", 0, 0, 2);
        issue(1, 0, 0);
        expect_txn("R3 read E", 1, 0, 0, 1, 4'b0001, 0);
        chk_st("R3 holder", 0, 0, 1);
        chk_st("R3 requester", 1, 0, 1);
        issue(2, 0, 0);
        expect_txn("R5 two sharers", 2, 0, 0, 2, 4'b0011, 0);
        issue(3, 1, 0);
        expect_txn("R9 write", 3, 0, 0, 0, 0, 0);
        chk_st("R9 writer", 3, 0, 3);
        chk_st("R9 inval", 0, 0, 0);
        chk_st("R9 inval", 2, 0, 0);
        issue(0, 0, 0);
        expect_txn("R4 MESI read M", 0, 1, 3, 1, 4'b1000, 0);
        chk_st("R4 holder", 3, 0, 1);
        chk_st("R4 requester", 0, 0, 1);
        issue(2, 0, 0);
        expect_txn("R5 sharers c0 c3", 2, 0, 0, 2, 4'b1001, 0);
        issue(0, 0, 0);
        expect_txn("R11 read hit", 0, 0, 0, 0, 0, 0);
        chk_st("R11", 0, 0, 1);
    endtask

    task automatic test_moesi();
        apply_reset(1);
        issue(0, 0, 1);
        expect_txn("R2 moesi cold", 0, 0, 0, 0, 0, 1);
        issue(1, 0, 1);
        expect_txn("R6 read E", 1, 0, 0, 1, 4'b0001, 0);
        chk_st("R6 owner", 0, 1, 4);
        issue(2, 0, 1);
        expect_txn("R7 owner only", 2, 0, 0, 1, 4'b0001, 0);
        issue(0, 2, 1);
        expect_txn("R10 evict O", 0, 1, 0, 0, 0, 0);
        chk_st("R10 evicted", 0, 1, 0);
        issue(3, 0, 1);
        expect_txn("R14 moesi S only", 3, 0, 0, 0, 0, 1);
        chk_st("R14", 3, 1, 1);
        issue(1, 1, 2);
        expect_txn("R9 cold write", 1, 0, 0, 0, 0, 0);
        issue(0, 0, 2);
        expect_txn("R6 read M", 0, 0, 0, 1, 4'b0010, 0);
        chk_st("R6 M to O", 1, 2, 4);
        issue(2, 1, 2);
        expect_txn("R9 write over O", 2, 1, 1, 0, 0, 0);
        chk_st("R9 O inval", 1, 2, 0);
        chk_st("R9 S inval", 0, 2, 0);
        chk_st("R9 writer", 2, 2, 3);
    endtask

    task automatic test_mesif();
        apply_reset(2);
        issue(0, 0, 2);
        issue(1, 0, 2);
        expect_txn("R8 read E", 1, 0, 0, 1, 4'b0001, 0);
        chk_st("R8 forward", 0, 2, 5);
        issue(2, 0, 2);
        expect_txn("R8 F only", 2, 0, 0, 1, 4'b0001, 0);
        issue(3, 1, 3);
        issue(0, 0, 3);
        expect_txn("R4 MESIF read M", 0, 1, 3, 1, 4'b1000, 0);
        chk_st("R4 mesif holder", 3, 3, 1);
        issue(1, 2, 2);
        expect_txn("R10 evict S", 1, 0, 0, 0, 0, 0);
        issue(0, 2, 2);
        expect_txn("R10 evict F", 0, 0, 0, 0, 0, 0);
        chk_st("R10 F gone", 0, 2, 0);
        issue(3, 0, 2);
        expect_txn("R14 mesif S only", 3, 0, 0, 0, 0, 1);
        chk_st("R14 mesif", 3, 2, 1);
    endtask

    task automatic wait_done(output int id);
        int cyc;
        cyc = 0; id = -1;
        forever begin
            @(negedge clk);
            cyc++;
            if (done_valid) begin id = int'(done_id); break; end
            if (cyc > 20) break;
        end
    endtask

    task automatic test_rr();
        int id;
        apply_reset(0);
        @(negedge clk);
        req_op = '0;
        req_line = 8'b00_01_00_00;
        req_valid = 4'b0101;
        wait_done(id); check("R12 first grant", id, 0); req_valid[0] = 1'b0;
        wait_done(id); check("R12 second grant", id, 2); req_valid[2] = 1'b0;
        req_valid = 4'b1010;
        wait_done(id); check("R12 wrap grant", id, 3); req_valid[3] = 1'b0;
        wait_done(id); check("R12 last grant", id, 1); req_valid[1] = 1'b0;
    endtask

    initial begin
        test_reset();
        test_mesi();
        test_moesi();
        test_mesif();
        test_rr();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule